// File: doc/BRIEF.md
# Soft-Decision K7 Viterbi Frame Decoder

This block decodes one frame of a rate 1/2, constraint length 7 convolutional code from 3-bit soft values. A controller fills an input store through a write port. Each entry holds one pair of soft values, one for each of the two code bits produced by one information bit. A single-cycle `start` then launches the decode. The block runs a forward pass of add-compare-select over all 64 trellis states, one information bit per clock. It then picks the state with the best final metric and traces back through the stored survivor decisions. The decoded frame is read one byte at a time through a combinational read port.

Each soft value is a confidence. A code bit expected as 1 scores the soft value, and a code bit expected as 0 scores its complement. The surviving path is the one with the larger accumulated score, not the one with the smaller distance. The whole frame is decoded as one block, with no sliding window and no streaming.

The controller is a five-state machine:
- `ST_IDLE` goes to `ST_FWD` on `start`.
- `ST_FWD` goes to `ST_PICK` after the last information bit.
- `ST_PICK` goes to `ST_BACK` after one cycle, loading the best state.
- `ST_BACK` goes to `ST_DONE` after bit 0 has been recovered.
- `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `soft_viterbi_k7`

## Requirements
- R1: A write with `wr_en` high at address k stores the soft pair for information bit k. `wr_g1` belongs to the code bit from generator 171 (octal) and `wr_g2` to the code bit from generator 133 (octal). The encoder starts at all-zero and shifts each new bit into the LSB of a 7-bit register. Each code bit is the parity of that register masked by its generator. A soft value of 7 means a confident 1 and 0 means a confident 0.
- R2: Frames written with confident values (7 or 0) that match the encoder output decode to exactly the original payload, for random, all-zero and all-one payloads.
- R3: Path metrics never overflow their width over a full default-size frame. The decoded output of a full 1072-bit frame equals the payload.
- R4: The path with the larger summed confidence wins. One fully inverted soft value at any code-bit position of information steps 0 to N−3 is corrected. Frames in which every value is weak (4 for a 1, 3 for a 0) decode exactly.
- R5: Bit j of output byte i holds decoded bit N−1−8·i−j, where N = 8·NBYTES and bit index 0 is the first information bit.
- R6: `busy` is high in the cycle after `start` is accepted. `done` is high for exactly one cycle, beginning 2N+1 clock edges after the accepting edge, and `busy` is low while `done` is high.
- R7: A `start` pulse while `busy` is high has no effect on the running decode or its completion time.
- R8: Writes while `busy` is high are ignored. The input store keeps its earlier contents, so a second `start` without reloading yields the same output.
- R9: A read address at or above NBYTES returns 0.
- R10: After reset `busy` and `done` are low and every output byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Soft pair write strobe |
| wr_addr | input | $clog2(8·NBYTES) | Information bit index of the pair |
| wr_g1 | input | SOFT_W | Soft value for the 171 code bit |
| wr_g2 | input | SOFT_W | Soft value for the 133 code bit |
| start | input | 1 | Begin decoding the stored frame |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | $clog2(NBYTES) | Output byte index |
| rd_data | output | 8 | Decoded byte |

## Verification
A corrupted path metric or a wrong survivor decision does not show at the ports until `done`. It then appears as one or more wrong decoded bits, usually in a burst near the bad step. The checks therefore read back every byte of every frame after each decode.

A control fault shows much sooner, as a shifted or missing `done` pulse. The completion cycle is counted exactly on each decode.

Single-error sweeps place the flipped value at every code-bit position of a short frame. A miswired branch metric or tie rule then shows as a decode failure tied to one trellis step.

// File: rtl/svit_pkg.sv
package svit_pkg;
    localparam int NST = 64;
    localparam logic [6:0] GEN_A = 7'o171;
    localparam logic [6:0] GEN_B = 7'o133;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD,
        ST_PICK,
        ST_BACK,
        ST_DONE
    } vit_state_t;

    // Expected code pair {a,b} leaving state prev on input bit b
    function automatic logic [1:0] code_pair(input logic [5:0] prev, input logic bin);
        logic [6:0] r;
        r = {prev, bin};
        return {^(r & GEN_A), ^(r & GEN_B)};
    endfunction
endpackage

// File: rtl/svit_bmu.sv
module svit_bmu #(
    parameter int SOFT_W = 3,
    parameter int BMW    = 4
) (
    input  logic [SOFT_W-1:0]      soft_a,
    input  logic [SOFT_W-1:0]      soft_b,
    output logic [3:0][BMW-1:0]    bm
);
    localparam int SMAX = (1 << SOFT_W) - 1;

    logic [BMW-1:0] conf_a [2];
    logic [BMW-1:0] conf_b [2];

    always_comb begin
        conf_a[1] = BMW'(soft_a);
        conf_a[0] = BMW'(SMAX) - BMW'(soft_a);
        conf_b[1] = BMW'(soft_b);
        conf_b[0] = BMW'(SMAX) - BMW'(soft_b);
    end

    for (genvar e = 0; e < 4; e++) begin : g_pair
        assign bm[e] = conf_a[(e >> 1) & 1] + conf_b[e & 1];
    end
endmodule

// File: rtl/svit_acs.sv
module svit_acs
    import svit_pkg::*;
#(
    parameter int BMW   = 4,
    parameter int MW    = 15,
    parameter int START = 15009,
    parameter int CAP   = 30017
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init,
    input  logic                     step,
    input  logic [3:0][BMW-1:0]      bm,
    output logic [NST-1:0]           dec,
    output logic [5:0]               best_state
);
    logic [NST-1:0][MW-1:0] pm_q;

    for (genvar g = 0; g < NST; g++) begin : g_state
        localparam logic [5:0] NS = 6'(g);
        localparam logic [5:0] P0 = {1'b0, NS[5:1]};
        localparam logic [5:0] P1 = {1'b1, NS[5:1]};
        localparam logic [1:0] E0 = code_pair(P0, NS[0]);
        localparam logic [1:0] E1 = code_pair(P1, NS[0]);

        logic [MW-1:0] cand0, cand1;
        logic          pick1;

        always_comb begin
            cand0 = pm_q[P0] + MW'(bm[E0]);
            cand1 = pm_q[P1] + MW'(bm[E1]);
            pick1 = cand1 > cand0;
        end

        assign dec[g] = pick1;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pm_q[g] <= '0;
            end else if (init) begin
                pm_q[g] <= (g == 0) ? MW'(START) : '0;
            end else if (step) begin
                pm_q[g] <= pick1 ? cand1 : cand0;
            end
        end

        // R3: metric stays below its ceiling
        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            pm_q[g] <= MW'(CAP));
    end

    // Best final state: linear scan, ties to the lowest index
    logic [MW-1:0] best_val;
    always_comb begin
        best_val   = pm_q[0];
        best_state = '0;
        for (int s = 1; s < NST; s++) begin
            if (pm_q[s] > best_val) begin
                best_val   = pm_q[s];
                best_state = 6'(s);
            end
        end
    end
endmodule

// File: rtl/svit_ctrl.sv
module svit_ctrl
    import svit_pkg::*;
#(
    parameter int NBITS = 1072,
    parameter int IDXW  = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [IDXW-1:0] t,
    output logic            init,
    output logic            step,
    output logic            seed,
    output logic            back,
    output logic            busy,
    output logic            done
);
    localparam logic [IDXW-1:0] LAST = IDXW'(NBITS - 1);

    vit_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_FWD;
            ST_FWD:  if (t == LAST) nxt = ST_PICK;
            ST_PICK: nxt = ST_BACK;
            ST_BACK: if (t == '0) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            t     <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: t <= '0;
                ST_FWD:  if (t != LAST) t <= t + 1'b1;
                ST_PICK: t <= LAST;
                ST_BACK: if (t != '0) t <= t - 1'b1;
                default: t <= t;
            endcase
        end
    end

    always_comb begin
        init = (state == ST_IDLE) && start;
        step = (state == ST_FWD);
        seed = (state == ST_PICK);
        back = (state == ST_BACK);
        busy = (state == ST_FWD) || (state == ST_PICK) || (state == ST_BACK);
        done = (state == ST_DONE);
    end

    // R7: a running forward pass advances one step per cycle whatever start does
    assert_fwd_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FWD && t != LAST) |=> (state == ST_FWD && t == $past(t) + 1'b1));
    // R6: last traceback step leads straight to the completion pulse
    assert_back_to_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BACK && t == '0) |=> done);
endmodule

// File: rtl/soft_viterbi_k7.sv
module soft_viterbi_k7
    import svit_pkg::*;
#(
    parameter int NBYTES = 134,
    parameter int SOFT_W = 3,
    localparam int NBITS = 8 * NBYTES,
    localparam int IDXW  = $clog2(NBITS),
    localparam int BYTEW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_addr,
    input  logic [SOFT_W-1:0] wr_g1,
    input  logic [SOFT_W-1:0] wr_g2,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic [BYTEW-1:0]  rd_addr,
    output logic [7:0]        rd_data
);
    localparam int SMAX  = (1 << SOFT_W) - 1;
    localparam int BMW   = $clog2(2 * SMAX + 1);
    localparam int START = 2 * SMAX * NBITS + 1;
    localparam int CAP   = 2 * START - 1;
    localparam int MW    = $clog2(CAP + 1);

    logic [2*SOFT_W-1:0] in_mem [NBITS];
    logic [NST-1:0]      surv   [NBITS];
    logic [NBITS-1:0]    dec_bits;
    logic [5:0]          tb_state;

    logic [IDXW-1:0]     t;
    logic                init, step, seed, back;
    logic [3:0][BMW-1:0] bm;
    logic [NST-1:0]      dec;
    logic [5:0]          best_state;
    logic [2*SOFT_W-1:0] cur_pair;

    svit_ctrl #(.NBITS(NBITS), .IDXW(IDXW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .t(t),
        .init(init), .step(step), .seed(seed), .back(back),
        .busy(busy), .done(done)
    );

    assign cur_pair = in_mem[t];

    svit_bmu #(.SOFT_W(SOFT_W), .BMW(BMW)) u_bmu (
        .soft_a(cur_pair[2*SOFT_W-1:SOFT_W]),
        .soft_b(cur_pair[SOFT_W-1:0]),
        .bm(bm)
    );

    svit_acs #(.BMW(BMW), .MW(MW), .START(START), .CAP(CAP)) u_acs (
        .clk(clk), .rst_n(rst_n), .init(init), .step(step),
        .bm(bm), .dec(dec), .best_state(best_state)
    );

    // Input store: writes accepted only while idle
    always_ff @(posedge clk) begin
        if (wr_en && !busy && (int'(wr_addr) < NBITS)) begin
            in_mem[wr_addr] <= {wr_g1, wr_g2};
        end
    end

    // Survivor decisions, one row per information step
    always_ff @(posedge clk) begin
        if (step) begin
            surv[t] <= dec;
        end
    end

    // Traceback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_state <= '0;
            dec_bits <= '0;
        end else if (seed) begin
            tb_state <= best_state;
        end else if (back) begin
            dec_bits[t] <= tb_state[0];
            tb_state    <= {surv[t][tb_state], tb_state[5:1]};
        end
    end

    // Output packing: byte i bit j <- decoded bit NBITS-1-8i-j
    logic [IDXW-1:0] rd_base;
    always_comb begin
        rd_data = '0;
        rd_base = IDXW'(NBITS - 1 - 8 * int'(rd_addr));
        if (int'(rd_addr) < NBYTES) begin
            for (int j = 0; j < 8; j++) begin
                rd_data[j] = dec_bits[rd_base - IDXW'(j)];
            end
        end
    end

    // R6: completion pulse is one cycle and never overlaps busy
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R8: a write during busy leaves the addressed entry unchanged
    assert_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && (int'(wr_addr) < NBITS))
        |=> in_mem[$past(wr_addr)] == $past(in_mem[wr_addr]));
endmodule

// File: tb/sim_soft_viterbi_k7.sv
module sim_soft_viterbi_k7;
    localparam int CLK_PERIOD = 10;
    localparam int SB = 4;
    localparam int SN = 8 * SB;
    localparam int BB = 134;
    localparam int BN = 8 * BB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       we0 = 0, st0 = 0, busy0, done0;
    logic [4:0] wa0 = '0;
    logic [2:0] a0 = '0, b0 = '0;
    logic [1:0] ra0 = '0;
    logic [7:0] rd0;

    logic        we1 = 0, st1 = 0, busy1, done1;
    logic [10:0] wa1 = '0;
    logic [2:0]  a1 = '0, b1 = '0;
    logic [7:0]  ra1 = '0;
    logic [7:0]  rd1;

    soft_viterbi_k7 #(.NBYTES(SB)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(we0), .wr_addr(wa0), .wr_g1(a0), .wr_g2(b0),
        .start(st0), .busy(busy0), .done(done0), .rd_addr(ra0), .rd_data(rd0)
    );
    soft_viterbi_k7 u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(we1), .wr_addr(wa1), .wr_g1(a1), .wr_g2(b1),
        .start(st1), .busy(busy1), .done(done1), .rd_addr(ra1), .rd_data(rd1)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic       pay [BN];
    logic [2:0] sa  [BN];
    logic [2:0] sb  [BN];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // kind: 0 random, 1 zeros, 2 ones, 3 only last bit set, 4 only first bit set
    task automatic make_frame(input int n, input int kind);
        logic [6:0] r;
        r = '0;
        for (int k = 0; k < n; k++) begin
            case (kind)
                0: pay[k] = 1'($urandom);
                1: pay[k] = 1'b0;
                2: pay[k] = 1'b1;
                3: pay[k] = (k == n - 1);
                default: pay[k] = (k == 0);
            endcase
            r = {r[5:0], pay[k]};
            sa[k] = (^(r & 7'o171)) ? 3'd7 : 3'd0;
            sb[k] = (^(r & 7'o133)) ? 3'd7 : 3'd0;
        end
    endtask

    task automatic weaken(input int n);
        for (int k = 0; k < n; k++) begin
            sa[k] = (sa[k] == 3'd7) ? 3'd4 : 3'd3;
            sb[k] = (sb[k] == 3'd7) ? 3'd4 : 3'd3;
        end
    endtask

    task automatic drive_wr(input int sel, input logic en, input int addr,
                            input logic [2:0] va, input logic [2:0] vb);
        if (sel == 0) begin we0 = en; wa0 = 5'(addr); a0 = va; b0 = vb; end
        else          begin we1 = en; wa1 = 11'(addr); a1 = va; b1 = vb; end
    endtask

    task automatic set_start(input int sel, input logic v);
        if (sel == 0) st0 = v; else st1 = v;
    endtask

    function automatic logic busy_of(input int sel);
        return (sel == 0) ? busy0 : busy1;
    endfunction

    function automatic logic done_of(input int sel);
        return (sel == 0) ? done0 : done1;
    endfunction

    task automatic read_byte(input int sel, input int i, output logic [7:0] v);
        if (sel == 0) ra0 = 2'(i); else ra1 = 8'(i);
        #1;
        v = (sel == 0) ? rd0 : rd1;
    endtask

    task automatic load(input int sel, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            drive_wr(sel, 1'b1, k, sa[k], sb[k]);
        end
        @(negedge clk);
        drive_wr(sel, 1'b0, 0, 3'd0, 3'd0);
    endtask

    // poke_st / poke_wr: cycle at which a stray start / write is applied (0 = none)
    task automatic decode(input int sel, input int n, input int poke_st, input int poke_wr);
        int  cyc;
        bit  seen;
        @(negedge clk);
        set_start(sel, 1'b1);
        @(negedge clk);
        set_start(sel, 1'b0);
        cyc  = 1;
        seen = 0;
        check(busy_of(sel) == 1'b1, "R6", "busy after start", int'(busy_of(sel)), 1);
        while (!seen && cyc < 3 * n + 20) begin
            if (done_of(sel)) begin
                seen = 1;
            end else begin
                if (cyc == poke_st) set_start(sel, 1'b1);
                if (cyc == poke_wr) drive_wr(sel, 1'b1, 3, 3'd7 - sa[3], 3'd7 - sb[3]);
                @(negedge clk);
                set_start(sel, 1'b0);
                drive_wr(sel, 1'b0, 0, 3'd0, 3'd0);
                cyc++;
            end
        end
        check(seen && cyc == 2 * n + 2, (poke_st != 0) ? "R7" : "R6",
              "done cycle", cyc, 2 * n + 2);
        check(busy_of(sel) == 1'b0, "R6", "busy during done", int'(busy_of(sel)), 0);
        @(negedge clk);
        check(done_of(sel) == 1'b0, "R6", "done width", int'(done_of(sel)), 0);
    endtask

    task automatic check_frame(input int sel, input int n, input string req, input string what);
        logic [7:0] got, exp;
        bit ok;
        int bad_a, bad_e;
        ok = 1; bad_a = 0; bad_e = 0;
        for (int i = 0; i < n / 8; i++) begin
            for (int j = 0; j < 8; j++) exp[j] = pay[n - 1 - 8 * i - j];
            read_byte(sel, i, got);
            if (ok && got != exp) begin
                ok = 0; bad_a = int'(got); bad_e = int'(exp);
            end
        end
        check(ok, req, what, bad_a, bad_e);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy0 == 1'b0 && done0 == 1'b0, "R10", "u0 busy/done", int'({busy0, done0}), 0);
        check(busy1 == 1'b0 && done1 == 1'b0, "R10", "u1 busy/done", int'({busy1, done1}), 0);
        read_byte(0, 0, v);
        check(v == 8'h00, "R10", "u0 byte0 after reset", int'(v), 0);
        read_byte(1, 0, v);
        check(v == 8'h00, "R10", "u1 byte0 after reset", int'(v), 0);
        rst_n = 1'b1;

        // R1, R2: clean frames of several kinds
        for (int f = 0; f < 8; f++) begin
            make_frame(SN, (f == 0) ? 1 : (f == 1) ? 2 : 0);
            load(0, SN);
            decode(0, SN, 0, 0);
            check_frame(0, SN, "R2", "R1 clean frame");
        end

        // R5: packing of single-bit frames
        make_frame(SN, 3);
        load(0, SN);
        decode(0, SN, 0, 0);
        read_byte(0, 0, v);
        check(v == 8'h01, "R5", "last bit in byte0 bit0", int'(v), 1);
        make_frame(SN, 4);
        load(0, SN);
        decode(0, SN, 0, 0);
        read_byte(0, SB - 1, v);
        check(v == 8'h80, "R5", "first bit in top byte bit7", int'(v), 128);

        // R4: single inverted soft value at every code position of steps 0..N-3
        for (int pos = 0; pos < 2 * (SN - 2); pos++) begin
            make_frame(SN, 0);
            if (pos % 2 == 0) sa[pos / 2] = 3'd7 - sa[pos / 2];
            else              sb[pos / 2] = 3'd7 - sb[pos / 2];
            load(0, SN);
            decode(0, SN, 0, 0);
            check_frame(0, SN, "R4", $sformatf("flip at code pos %0d", pos));
        end

        // R4: all-weak frames
        for (int f = 0; f < 3; f++) begin
            make_frame(SN, (f == 0) ? 2 : 0);
            weaken(SN);
            load(0, SN);
            decode(0, SN, 0, 0);
            check_frame(0, SN, "R4", "weak frame");
        end

        // R7 and R8: stray start and stray write during decode
        make_frame(SN, 0);
        load(0, SN);
        decode(0, SN, 10, 20);
        check_frame(0, SN, "R7", "output with stray start");
        decode(0, SN, 0, 0);
        check_frame(0, SN, "R8", "rerun after write during busy");

        // R3: full-size frames
        make_frame(BN, 2);
        load(1, BN);
        decode(1, BN, 0, 0);
        check_frame(1, BN, "R3", "full all-ones frame");
        make_frame(BN, 0);
        sa[100] = 3'd7 - sa[100];
        sb[600] = 3'd7 - sb[600];
        load(1, BN);
        decode(1, BN, 0, 0);
        check_frame(1, BN, "R3", "full random frame with two flips");

        // R9: out-of-range byte addresses
        read_byte(1, 200, v);
        check(v == 8'h00, "R9", "byte 200", int'(v), 0);
        read_byte(1, BB, v);
        check(v == 8'h00, "R9", "byte NBYTES", int'(v), 0);

        finish_run();
    end
endmodule